// File: doc/BRIEF.md
# Bus Handshake Timeout Supervisor

This block supervises the request/acknowledge handshake of a parallel SCSI protocol controller, together with two other timed bus activities. It counts a shared prescaled tick while a watched condition is open and raises a sticky timeout flag when a programmed limit is reached. It reads the controller's role, either target or initiator, and the transfer type, either interlocked asynchronous or offset-based synchronous. From these it decides which edge of REQ or ACK opens the handshake window and which event closes it.

Next to the handshake watch sit three further timers. The first measures the wait before a failed selection or reselection is retried. The second watches how long the controller's internal busy condition has lasted. The third paces the assertion of REQ or ACK for asynchronous data bytes and reports each elapsed interval as a one-cycle strobe. The surrounding controller drives the bus, sequences the phases, keeps the outstanding synchronous offset count and clears flags with a write-one-to-clear strobe.

Top module: `hsk_timeout_sup`

## Requirements
- R1: Asynchronous target (`syncMode`=0, `roleTarget`=1): a rising `reqIn` opens the handshake window and a high `ackIn` closes it. If `limHsk` ticks arrive after the opening cycle with the window still open, `hskTimeout` is set in the cycle after the last of those ticks.
- R2: Asynchronous initiator (`syncMode`=0, `roleTarget`=0): a rising `ackIn` opens the handshake window and a low `reqIn` closes it. The tick count and the flag timing are the same as in R1.
- R3: Synchronous target (`syncMode`=1, `roleTarget`=1): a rising `reqIn` opens the window. Only a rising `ackIn` seen while `offsetCnt` equals 1 closes it, because that is the acknowledge that returns the outstanding offset to zero. Other acknowledges leave the window open. In synchronous initiator mode the handshake is never timed.
- R4: A one-cycle `retryReq` arms the retry timer. `retryTimeout` is set in the cycle after the `limRetry`-th following tick.
- R5: While `busyIn` is high the busy timer runs. `busyTimeout` is set in the cycle after the `limBusy`-th tick of an unbroken busy stretch. A low `busyIn` clears the count.
- R6: A `paceReq` pulse starts a pacing interval. `paceGo` is high for exactly one cycle, in the cycle after the `limPace`-th following tick. With `limPace`=0, `paceGo` is high in the cycle right after the request.
- R7: A limit of zero disables the handshake, retry and busy timeouts: no flag is ever set for them.
- R8: The flags are sticky until a one is written to their bit of `clrFlags` (bit 0 handshake, bit 1 retry, bit 2 busy). The flag reads zero in the cycle after that write. An expiry in the same cycle as the clear leaves the flag set.
- R9: When an opening event and a closing event arrive in the same cycle, the window does not open and no timeout follows.
- R10: When a closing event falls in the same cycle as the tick that would reach the limit, no timeout is recorded.
- R11: After reset all flags and `paceGo` are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| tickIn | input | 1 | Shared prescaled time tick, one cycle wide |
| roleTarget | input | 1 | 1 = controller acts as target, 0 = initiator |
| syncMode | input | 1 | 1 = synchronous transfer, 0 = asynchronous |
| reqIn | input | 1 | REQ line level, asserted high |
| ackIn | input | 1 | ACK line level, asserted high |
| offsetCnt | input | OFS_W | Outstanding synchronous offset, before the current ACK is applied |
| retryReq | input | 1 | Pulse: selection failed, start the retry wait |
| busyIn | input | 1 | Internal controller busy level |
| paceReq | input | 1 | Pulse: start one asynchronous pacing interval |
| limHsk | input | LIM_W | Handshake limit in ticks, 0 = off |
| limRetry | input | LIM_W | Retry interval in ticks, 0 = off |
| limBusy | input | LIM_W | Busy limit in ticks, 0 = off |
| limPace | input | LIM_W | Pacing interval in ticks, 0 = no delay |
| clrFlags | input | 3 | Write-one-to-clear strobes for the three flags |
| hskTimeout | output | 1 | Sticky handshake timeout flag |
| retryTimeout | output | 1 | Sticky retry interval flag |
| busyTimeout | output | 1 | Sticky busy timeout flag |
| paceGo | output | 1 | One-cycle strobe: pacing interval elapsed |

## Verification
The cases that matter most are two events landing in one clock edge. In the first, a flag's clearing write lands in the same cycle as a fresh expiry of that timer. The bench first leaves the retry flag set, arms the retry timer again and then drives `clrFlags` bit 1 together with the final tick. The flag must stay set, and a clear on its own afterwards must drop it. In the second, an opening and a closing handshake event land together: REQ and ACK rise in the same cycle, and the bench also closes the window on the very tick that would reach the limit. In both cases the flag must stay low for many ticks afterwards.

// File: rtl/hts_pkg.sv
package hts_pkg;

  // timer slots; the first three also index the sticky flags and clrFlags
  localparam int T_HSK   = 0;
  localparam int T_RETRY = 1;
  localparam int T_BUSY  = 2;
  localparam int T_PACE  = 3;
  localparam int NT      = 4;
  localparam int NFLAG   = 3;

  typedef struct packed {
    logic [NT-1:0] start;
    logic [NT-1:0] stop;
  } hts_strobe_t;

endpackage

// File: rtl/hts_timer.sv
module hts_timer #(
  parameter int CW = 16
) (
  input  logic          clk,
  input  logic          rstN,
  input  logic          tick,
  input  logic          start,
  input  logic          stop,
  input  logic [CW-1:0] limit,
  output logic          expire
);

  logic          armed;
  logic [CW-1:0] cnt;
  logic          limZero;

  assign limZero = (limit == '0);

  // the tick that reaches the limit; a stop in the same cycle suppresses it
  assign expire = armed && tick && !stop && (cnt == limit - CW'(1));

  always_ff @(posedge clk) begin
    if (!rstN) begin
      armed <= 1'b0;
      cnt   <= '0;
    end else if (stop || expire || limZero) begin
      armed <= 1'b0;
      cnt   <= '0;
    end else if (!armed) begin
      armed <= start;
      cnt   <= '0;
    end else if (tick) begin
      cnt <= cnt + CW'(1);
    end
  end

endmodule

// File: rtl/hts_ctrl.sv
module hts_ctrl
  import hts_pkg::*;
#(
  parameter int OFS_W = 6
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             roleTarget,
  input  logic             syncMode,
  input  logic             reqIn,
  input  logic             ackIn,
  input  logic [OFS_W-1:0] offsetCnt,
  input  logic             retryReq,
  input  logic             busyIn,
  input  logic             paceReq,
  output hts_strobe_t      strb
);

  logic reqQ, ackQ;
  logic reqRise, ackRise;
  logic lastAck;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      reqQ <= 1'b0;
      ackQ <= 1'b0;
    end else begin
      reqQ <= reqIn;
      ackQ <= ackIn;
    end
  end

  assign reqRise = reqIn && !reqQ;
  assign ackRise = ackIn && !ackQ;
  assign lastAck = ackRise && (offsetCnt == OFS_W'(1));

  always_comb begin
    strb = '0;
    // handshake window: open/close depend on role and transfer type
    unique case ({syncMode, roleTarget})
      2'b01: begin
        strb.start[T_HSK] = reqRise;
        strb.stop[T_HSK]  = ackIn;
      end
      2'b00: begin
        strb.start[T_HSK] = ackRise;
        strb.stop[T_HSK]  = !reqIn;
      end
      2'b11: begin
        strb.start[T_HSK] = reqRise;
        strb.stop[T_HSK]  = lastAck;
      end
      default: begin
        strb.start[T_HSK] = 1'b0;
        strb.stop[T_HSK]  = 1'b1;
      end
    endcase
    strb.start[T_RETRY] = retryReq;
    strb.stop[T_RETRY]  = 1'b0;
    strb.start[T_BUSY]  = busyIn;
    strb.stop[T_BUSY]   = !busyIn;
    strb.start[T_PACE]  = paceReq;
    strb.stop[T_PACE]   = 1'b0;
  end

endmodule

// File: rtl/hts_datapath.sv
module hts_datapath
  import hts_pkg::*;
#(
  parameter int LIM_W = 16
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             tickIn,
  input  hts_strobe_t      strb,
  input  logic [LIM_W-1:0] limHsk,
  input  logic [LIM_W-1:0] limRetry,
  input  logic [LIM_W-1:0] limBusy,
  input  logic [LIM_W-1:0] limPace,
  input  logic [NFLAG-1:0] clrFlags,
  output logic [NFLAG-1:0] flags,
  output logic             paceGo
);

  logic [LIM_W-1:0] limArr [NT];
  logic [NT-1:0]    expire;
  logic [NFLAG-1:0] flagQ;
  logic             paceGoQ;

  assign limArr[T_HSK]   = limHsk;
  assign limArr[T_RETRY] = limRetry;
  assign limArr[T_BUSY]  = limBusy;
  assign limArr[T_PACE]  = limPace;

  for (genvar i = 0; i < NT; i++) begin : g_tmr
    hts_timer #(.CW(LIM_W)) tmr_i (
      .clk    (clk),
      .rstN   (rstN),
      .tick   (tickIn),
      .start  (strb.start[i]),
      .stop   (strb.stop[i]),
      .limit  (limArr[i]),
      .expire (expire[i])
    );
  end

  // sticky flags: a new expiry outranks a clear in the same cycle
  for (genvar f = 0; f < NFLAG; f++) begin : g_flag
    always_ff @(posedge clk) begin
      if (!rstN)          flagQ[f] <= 1'b0;
      else if (expire[f]) flagQ[f] <= 1'b1;
      else if (clrFlags[f]) flagQ[f] <= 1'b0;
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) paceGoQ <= 1'b0;
    else       paceGoQ <= expire[T_PACE] || (strb.start[T_PACE] && (limPace == '0));
  end

  assign flags  = flagQ;
  assign paceGo = paceGoQ;

endmodule

// File: rtl/hsk_timeout_sup.sv
module hsk_timeout_sup
  import hts_pkg::*;
#(
  parameter int OFS_W = 6,
  parameter int LIM_W = 16
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             tickIn,
  input  logic             roleTarget,
  input  logic             syncMode,
  input  logic             reqIn,
  input  logic             ackIn,
  input  logic [OFS_W-1:0] offsetCnt,
  input  logic             retryReq,
  input  logic             busyIn,
  input  logic             paceReq,
  input  logic [LIM_W-1:0] limHsk,
  input  logic [LIM_W-1:0] limRetry,
  input  logic [LIM_W-1:0] limBusy,
  input  logic [LIM_W-1:0] limPace,
  input  logic [2:0]       clrFlags,
  output logic             hskTimeout,
  output logic             retryTimeout,
  output logic             busyTimeout,
  output logic             paceGo
);

  hts_strobe_t      strb;
  logic [NFLAG-1:0] flags;

  hts_ctrl #(.OFS_W(OFS_W)) ctrl_i (
    .clk        (clk),
    .rstN       (rstN),
    .roleTarget (roleTarget),
    .syncMode   (syncMode),
    .reqIn      (reqIn),
    .ackIn      (ackIn),
    .offsetCnt  (offsetCnt),
    .retryReq   (retryReq),
    .busyIn     (busyIn),
    .paceReq    (paceReq),
    .strb       (strb)
  );

  hts_datapath #(.LIM_W(LIM_W)) dp_i (
    .clk      (clk),
    .rstN     (rstN),
    .tickIn   (tickIn),
    .strb     (strb),
    .limHsk   (limHsk),
    .limRetry (limRetry),
    .limBusy  (limBusy),
    .limPace  (limPace),
    .clrFlags (clrFlags),
    .flags    (flags),
    .paceGo   (paceGo)
  );

  assign hskTimeout   = flags[T_HSK];
  assign retryTimeout = flags[T_RETRY];
  assign busyTimeout  = flags[T_BUSY];

endmodule

// File: rtl/hts_checker.sv
module hts_checker #(
  parameter int OFS_W = 6,
  parameter int LIM_W = 16
) (
  input logic             clk,
  input logic             rstN,
  input logic             tickIn,
  input logic             busyIn,
  input logic             paceReq,
  input logic [LIM_W-1:0] limHsk,
  input logic [LIM_W-1:0] limRetry,
  input logic [LIM_W-1:0] limPace,
  input logic [2:0]       clrFlags,
  input logic             hskTimeout,
  input logic             retryTimeout,
  input logic             busyTimeout,
  input logic             paceGo
);

  p_hsk_sticky_r8: assert property (@(posedge clk) disable iff (!rstN)
    hskTimeout && !clrFlags[0] |=> hskTimeout);

  p_retry_sticky_r8: assert property (@(posedge clk) disable iff (!rstN)
    retryTimeout && !clrFlags[1] |=> retryTimeout);

  p_busy_sticky_r8: assert property (@(posedge clk) disable iff (!rstN)
    busyTimeout && !clrFlags[2] |=> busyTimeout);

  p_hsk_on_tick_r1: assert property (@(posedge clk) disable iff (!rstN)
    $rose(hskTimeout) |-> $past(tickIn));

  p_hsk_zero_off_r7: assert property (@(posedge clk) disable iff (!rstN)
    $rose(hskTimeout) |-> $past(limHsk) != '0);

  p_retry_zero_off_r7: assert property (@(posedge clk) disable iff (!rstN)
    $rose(retryTimeout) |-> ($past(limRetry) != '0) && $past(tickIn));

  p_busy_level_r5: assert property (@(posedge clk) disable iff (!rstN)
    $rose(busyTimeout) |-> $past(busyIn) && $past(tickIn));

  p_pace_cause_r6: assert property (@(posedge clk) disable iff (!rstN)
    paceGo |-> $past(tickIn) || ($past(paceReq) && ($past(limPace) == '0)));

endmodule

bind hsk_timeout_sup hts_checker #(.OFS_W(OFS_W), .LIM_W(LIM_W)) chk_i (.*);

// File: tb/hsk_timeout_sup_tb_top.sv
`timescale 1ns/1ps
module hsk_timeout_sup_tb_top;

  localparam int OFS_W = 6;
  localparam int LIM_W = 16;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic tickIn = 1'b0, roleTarget = 1'b1, syncMode = 1'b0;
  logic reqIn = 1'b0, ackIn = 1'b0, retryReq = 1'b0, busyIn = 1'b0, paceReq = 1'b0;
  logic [OFS_W-1:0] offsetCnt = '0;
  logic [LIM_W-1:0] limHsk = '0, limRetry = '0, limBusy = '0, limPace = '0;
  logic [2:0] clrFlags = '0;
  logic hskTimeout, retryTimeout, busyTimeout, paceGo;

  int checks = 0;
  int errors = 0;

  always #4 clk = ~clk;

  hsk_timeout_sup #(.OFS_W(OFS_W), .LIM_W(LIM_W)) dut_i (.*);

  task automatic check(input logic act, input logic exp, input string req);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%0b expected=%0b at %0t", req, act, exp, $time);
    end
  endtask

  task automatic step(input int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  // each tick occupies one edge, followed by one edge without tick
  task automatic ticks(input int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk) tickIn = 1'b1;
      @(negedge clk) tickIn = 1'b0;
    end
  endtask

  task automatic clearAll();
    @(negedge clk) clrFlags = 3'b111;
    @(negedge clk) clrFlags = 3'b000;
  endtask

  task automatic t_reset();
    check(hskTimeout, 1'b0, "R11 hsk");
    check(retryTimeout, 1'b0, "R11 retry");
    check(busyTimeout, 1'b0, "R11 busy");
    check(paceGo, 1'b0, "R11 pace");
  endtask

  task automatic t_async_target();
    syncMode = 0; roleTarget = 1; limHsk = 5;
    @(negedge clk) reqIn = 1;
    ticks(4);
    check(hskTimeout, 1'b0, "R1 before limit");
    ticks(1);
    check(hskTimeout, 1'b1, "R1 at limit");
    step(1);
    check(hskTimeout, 1'b1, "R8 sticky");
    @(negedge clk) clrFlags = 3'b001;
    @(negedge clk) clrFlags = 3'b000;
    check(hskTimeout, 1'b0, "R8 cleared");
    ackIn = 1; step(1); reqIn = 0; step(1); ackIn = 0; step(1);
    // ACK closes the window early
    @(negedge clk) reqIn = 1;
    ticks(3);
    @(negedge clk) ackIn = 1;
    ticks(8);
    check(hskTimeout, 1'b0, "R1 ack stops");
    reqIn = 0; step(1); ackIn = 0; step(1);
  endtask

  task automatic t_async_init();
    syncMode = 0; roleTarget = 0; limHsk = 5;
    @(negedge clk) reqIn = 1;
    @(negedge clk) ackIn = 1;
    ticks(4);
    check(hskTimeout, 1'b0, "R2 before limit");
    ticks(1);
    check(hskTimeout, 1'b1, "R2 at limit");
    reqIn = 0; step(1); ackIn = 0; step(1);
    clearAll();
    @(negedge clk) reqIn = 1;
    @(negedge clk) ackIn = 1;
    ticks(2);
    @(negedge clk) reqIn = 0;
    ticks(8);
    check(hskTimeout, 1'b0, "R2 req low stops");
    ackIn = 0; step(1);
  endtask

  task automatic t_sync();
    syncMode = 1; roleTarget = 1; limHsk = 6;
    @(negedge clk) reqIn = 1;
    @(negedge clk) reqIn = 0; offsetCnt = 2;
    @(negedge clk) ackIn = 1;
    @(negedge clk) ackIn = 0; offsetCnt = 1;
    ticks(6);
    check(hskTimeout, 1'b1, "R3 non-final ack keeps window");
    clearAll();
    offsetCnt = 0;
    @(negedge clk) reqIn = 1;
    @(negedge clk) reqIn = 0; offsetCnt = 1;
    ticks(2);
    @(negedge clk) ackIn = 1;
    @(negedge clk) ackIn = 0; offsetCnt = 0;
    ticks(10);
    check(hskTimeout, 1'b0, "R3 final ack stops");
    roleTarget = 0;
    @(negedge clk) reqIn = 1;
    @(negedge clk) ackIn = 1;
    ticks(10);
    check(hskTimeout, 1'b0, "R3 sync initiator untimed");
    reqIn = 0; ackIn = 0; step(1);
    syncMode = 0; roleTarget = 1;
  endtask

  task automatic t_retry();
    limRetry = 3;
    @(negedge clk) retryReq = 1;
    @(negedge clk) retryReq = 0;
    ticks(2);
    check(retryTimeout, 1'b0, "R4 before interval");
    ticks(1);
    check(retryTimeout, 1'b1, "R4 interval elapsed");
    // re-arm and let expiry meet a clear on the same edge
    limRetry = 2;
    @(negedge clk) retryReq = 1;
    @(negedge clk) retryReq = 0;
    ticks(1);
    @(negedge clk) begin tickIn = 1; clrFlags = 3'b010; end
    @(negedge clk) begin tickIn = 0; clrFlags = 3'b000; end
    check(retryTimeout, 1'b1, "R8 expiry beats clear");
    clearAll();
    check(retryTimeout, 1'b0, "R8 clear alone");
  endtask

  task automatic t_busy();
    limBusy = 4;
    @(negedge clk) busyIn = 1;
    ticks(3);
    @(negedge clk) busyIn = 0;
    @(negedge clk) busyIn = 1;
    ticks(3);
    check(busyTimeout, 1'b0, "R5 gap restarts count");
    ticks(1);
    check(busyTimeout, 1'b1, "R5 long busy");
    busyIn = 0;
    clearAll();
  endtask

  task automatic t_pace();
    limPace = 3;
    @(negedge clk) paceReq = 1;
    @(negedge clk) paceReq = 0;
    ticks(2);
    check(paceGo, 1'b0, "R6 before interval");
    @(negedge clk) tickIn = 1;
    @(negedge clk) tickIn = 0;
    check(paceGo, 1'b1, "R6 strobe");
    step(1);
    check(paceGo, 1'b0, "R6 single cycle");
    limPace = 0;
    @(negedge clk) paceReq = 1;
    @(negedge clk) paceReq = 0;
    check(paceGo, 1'b1, "R6 zero delay");
    step(1);
    check(paceGo, 1'b0, "R6 zero delay single");
  endtask

  task automatic t_zero_limit();
    limHsk = 0; limRetry = 0; limBusy = 0;
    @(negedge clk) begin reqIn = 1; retryReq = 1; busyIn = 1; end
    @(negedge clk) retryReq = 0;
    ticks(20);
    check(hskTimeout, 1'b0, "R7 hsk off");
    check(retryTimeout, 1'b0, "R7 retry off");
    check(busyTimeout, 1'b0, "R7 busy off");
    reqIn = 0; busyIn = 0; step(1);
  endtask

  task automatic t_same_cycle();
    limHsk = 3;
    @(negedge clk) begin reqIn = 1; ackIn = 1; end
    ticks(10);
    check(hskTimeout, 1'b0, "R9 start and stop together");
    reqIn = 0; step(1); ackIn = 0; step(1);
    @(negedge clk) reqIn = 1;
    ticks(2);
    @(negedge clk) begin tickIn = 1; ackIn = 1; end
    @(negedge clk) tickIn = 0;
    ticks(5);
    check(hskTimeout, 1'b0, "R10 stop on final tick");
    reqIn = 0; step(1); ackIn = 0; step(1);
  endtask

  initial begin
    #(200000 * 8);
    errors++;
    $display("FAIL watchdog expired");
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    step(4);
    rstN = 1;
    step(1);
    t_reset();
    t_async_target();
    t_async_init();
    t_sync();
    t_retry();
    t_busy();
    t_pace();
    t_zero_limit();
    t_same_cycle();
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule